// File: doc/BRIEF.md
# Raster Line Fetch and Shared Memory Arbiter

This block lets a CPU port and a display line buffer share one external static memory bus, with a 17-bit address and 8-bit data. When the raster timing logic asks for a line, the block reads that line's bytes from a frame region of external memory. It reads them back to back, one byte per clock, and stores them in an on-chip buffer. The display side reads this buffer through its own port at any time, even while a fetch is writing to it.

Outside a fetch, the CPU issues single-byte reads and writes with a request/ready handshake. A line fetch wins over the CPU. A CPU request that is waiting when a fetch begins is held off, with ready low, until the burst is over. A CPU access that has already started completes before the fetch takes the bus. A line's start address is the frame base plus the line index times the bytes per line. A one-cycle done pulse marks the storing of the last byte.

Top module: `lbuf_fetch_arb`

## Requirements
- R1: After reset, mem_we_n and mem_oe_n are both high, and cpu_rdy and line_done are both low.
- R2: A CPU read (cpu_we=0) drives mem_oe_n low for one cycle. cpu_rdy is then high for exactly one cycle, and while it is high cpu_rdata holds the byte stored at cpu_addr.
- R3: A CPU write (cpu_we=1) drives mem_we_n low for exactly one cycle, with cpu_addr and cpu_wdata on the bus. mem_we_n and mem_oe_n are never low in the same cycle.
- R4: A line fetch reads LINE_BYTES consecutive addresses, one per cycle, with mem_oe_n held low and mem_we_n held high. It starts at FB_BASE + line_idx * LINE_BYTES.
- R5: After line_done, buffer entry i holds the external byte at the start address + i. This includes bytes the CPU wrote earlier.
- R6: line_done is a single-cycle pulse. For a request that arrives while the bus is idle, it is high in the cycle LINE_BYTES+1 clocks after the edge that samples line_req.
- R7: When line_req and cpu_req are sampled together on an idle bus, the fetch runs first. cpu_rdy is never high during a burst and rises only after line_done.
- R8: A CPU access that is already in progress when line_req arrives completes first. Its cpu_rdy comes before line_done, and the fetch then runs normally.
- R9: disp_data shows buffer entry disp_addr one clock after disp_addr is applied. An entry that the ongoing fetch has not yet reached still returns the previous line's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU access request, held until cpu_rdy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, valid with cpu_rdy |
| cpu_rdy | output | 1 | One-cycle completion strobe |
| line_req | input | 1 | One-cycle line fetch request |
| line_idx | input | LW | Index of the line to fetch |
| line_done | output | 1 | One-cycle pulse after the last byte is stored |
| mem_addr | output | AW | External address |
| mem_wdata | output | 8 | External write data |
| mem_rdata | input | 8 | External read data |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| disp_addr | input | BW | Display read index into the line buffer |
| disp_data | output | 8 | Buffer byte, one cycle after disp_addr |

## Verification
A fetch counter or address register that goes wrong shows at the ports within a single burst. The run of mem_oe_n-low cycles has the wrong length or start address, and the line_done pulse moves away from the LINE_BYTES+1 latency. An arbitration state error shows as a cpu_rdy inside a burst, as a request that is lost or repeated, or as enables that overlap, all within a few cycles. A wrong buffer write index is only seen when the display port reads back the affected entry, so every entry is read back after a fetch.

// File: rtl/lbuf_fetch_arb.sv
module lbuf_fetch_arb #(
  parameter int AW         = 17,
  parameter int LW         = 8,
  parameter int LINE_BYTES = 64,
  parameter int FB_BASE    = 'h4000,
  localparam int BW        = $clog2(LINE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          cpu_rdy,
  input  logic          line_req,
  input  logic [LW-1:0] line_idx,
  output logic          line_done,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  input  logic [BW-1:0] disp_addr,
  output logic [7:0]    disp_data
);
  localparam logic [AW-1:0] BASE_A = AW'(FB_BASE);
  localparam logic [BW-1:0] LAST   = BW'(LINE_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_CPU, S_FETCH} st_t;

  st_t           st;
  logic          pend;
  logic [LW-1:0] pidx;
  logic [AW-1:0] faddr, c_addr;
  logic [BW-1:0] cnt;
  logic          c_we;
  logic [7:0]    c_wd;
  logic [7:0]    lbuf [LINE_BYTES];

  logic [LW-1:0] sel_idx;
  logic [AW-1:0] start_a;
  assign sel_idx = line_req ? line_idx : pidx;
  assign start_a = BASE_A + AW'(sel_idx) * AW'(LINE_BYTES);

  assign mem_addr  = (st == S_FETCH) ? faddr : c_addr;
  assign mem_wdata = c_wd;
  assign mem_oe_n  = !((st == S_FETCH) || (st == S_CPU && !c_we));
  assign mem_we_n  = !(st == S_CPU && c_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pend      <= 1'b0;
      pidx      <= '0;
      faddr     <= '0;
      cnt       <= '0;
      c_addr    <= '0;
      c_we      <= 1'b0;
      c_wd      <= '0;
      cpu_rdy   <= 1'b0;
      cpu_rdata <= '0;
      line_done <= 1'b0;
    end else begin
      cpu_rdy   <= 1'b0;
      line_done <= 1'b0;
      if (line_req && st != S_IDLE) begin
        pend <= 1'b1;
        pidx <= line_idx;
      end
      case (st)
        S_IDLE:
          if (line_req || pend) begin
            st    <= S_FETCH;
            pend  <= 1'b0;
            faddr <= start_a;
            cnt   <= '0;
          end else if (cpu_req && !cpu_rdy) begin
            st     <= S_CPU;
            c_addr <= cpu_addr;
            c_we   <= cpu_we;
            c_wd   <= cpu_wdata;
          end
        S_CPU: begin
          st      <= S_IDLE;
          cpu_rdy <= 1'b1;
          if (!c_we) cpu_rdata <= mem_rdata;
        end
        S_FETCH: begin
          faddr <= faddr + 1'b1;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            st        <= S_IDLE;
            line_done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FETCH) lbuf[cnt] <= mem_rdata;
    disp_data <= lbuf[disp_addr];
  end

  assert_no_bus_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_fetch_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |-> (mem_we_n && !mem_oe_n));

  assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && $past(st) == S_FETCH) |-> (mem_addr == $past(mem_addr) + 1'b1));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  assert_rdy_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |=> !cpu_rdy);

  assert_no_rdy_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |-> !cpu_rdy);
endmodule

// File: tb/lbuf_fetch_arb_tb.sv
module lbuf_fetch_arb_tb;
  localparam int AW = 17, LW = 8, N = 64, BW = 6, BASE = 'h4000;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_rdy, line_req = 0, line_done;
  logic [LW-1:0] line_idx = '0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_we_n, mem_oe_n;
  logic [BW-1:0] disp_addr = '0;
  logic [7:0] disp_data;

  always #4 clk = ~clk;

  lbuf_fetch_arb u_dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  int rdy_cyc = 0, done_cyc = 0, clash = 0, wlow = 0;
  int run = 0, last_run = 0, step_err = 0;
  logic [AW-1:0] first_a = '0, last_first = '0, prev_a = '0;
  logic [7:0] wmem [int];
  logic [8:0] cq[$];
  logic [7:0] dq[$];
  string dtag[$];
  logic d_iss = 0, d_stg = 0;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] + a[15:8] * 8'd3 + {7'd0, a[16]};
  endfunction
  function automatic logic [7:0] rdm(input logic [AW-1:0] a);
    if (wmem.exists(int'(a))) return wmem[int'(a)];
    return pat(a);
  endfunction

  assign mem_rdata = mem_oe_n ? 8'h00 : rdm(mem_addr);
  always @(posedge clk) begin
    cyc++;
    if (!mem_we_n) wmem[int'(mem_addr)] = mem_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitors
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && !mem_oe_n) clash++;
    if (!mem_we_n) wlow++;
    if (!mem_oe_n && mem_we_n) begin
      if (run == 0) first_a = mem_addr;
      else if (mem_addr != prev_a + 1'b1) step_err++;
      prev_a = mem_addr;
      run++;
    end else if (run > 0) begin
      last_run = run; last_first = first_a; run = 0;
    end
    if (line_done) done_cyc = cyc;
    if (cpu_rdy) begin
      logic [8:0] e;
      rdy_cyc = cyc;
      e = cq.pop_front();
      if (e[8]) chk("R2 cpu read data", cpu_rdata, e[7:0]);
    end
    if (d_stg) chk(dtag.pop_front(), disp_data, dq.pop_front());
    d_stg = d_iss;
    d_iss = 0;
  end

  task automatic cpu_acc(input logic we, input logic [AW-1:0] a, input logic [7:0] wd, input logic [7:0] exp);
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cq.push_back({!we, exp});
    do @(negedge clk); while (!cpu_rdy);
    @(posedge clk); #1 cpu_req = 0;
  endtask

  task automatic line_pulse(input logic [LW-1:0] idx);
    @(posedge clk); #1 line_req = 1; line_idx = idx;
    @(posedge clk); #1 line_req = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!line_done);
    @(negedge clk);
  endtask

  task automatic disp_rd(input logic [BW-1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 disp_addr = a; d_iss = 1;
    dq.push_back(exp); dtag.push_back(tag);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [AW-1:0] sa;
    int lat;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 we_n", mem_we_n, 1); chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 rdy", cpu_rdy, 0);   chk("R1 done", line_done, 0);

    cpu_acc(0, 17'h00010, 0, pat(17'h00010));
    cpu_acc(0, 17'h1FFFF, 0, pat(17'h1FFFF));
    cpu_acc(0, 17'h0ABCD, 0, pat(17'h0ABCD));

    cpu_acc(1, 17'h01234, 8'hA5, 0);
    cpu_acc(1, 17'h00007, 8'h3C, 0);
    chk("R3 write strobe cycles", wlow, 2);
    cpu_acc(0, 17'h01234, 0, 8'hA5);
    cpu_acc(0, 17'h00007, 0, 8'h3C);

    // R6 latency and R4 burst shape from idle
    line_pulse(3);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!line_done);
    chk("R6 done latency", lat, N + 1);
    @(negedge clk);
    chk("R6 done single cycle", line_done, 0);
    @(negedge clk);
    sa = 17'(BASE + 3 * N);
    chk("R4 burst start", last_first, sa);
    chk("R4 burst length", last_run, N);
    for (int i = 0; i < N; i++) disp_rd(BW'(i), rdm(sa + 17'(i)), "R5 line 3 entry");
    drain();

    // R5 CPU data visible to fetch; top line index
    cpu_acc(1, 17'(BASE + 7 * N + 5), 8'h77, 0);
    line_pulse(7); wait_done();
    disp_rd(5, 8'h77, "R5 cpu-written byte");
    line_pulse(255); wait_done();
    chk("R4 start top line", last_first, 17'(BASE + 255 * N));
    sa = 17'(BASE + 255 * N);
    disp_rd(0, rdm(sa), "R5 top line entry 0");
    disp_rd(63, rdm(sa + 17'd63), "R5 top line entry 63");
    drain();

    // R9 read during fetch sees old contents
    fork
      line_pulse(5);
      for (int k = 0; k < 8; k++) disp_rd(63, rdm(sa + 17'd63), "R9 old entry during fetch");
    join
    wait_done();
    disp_rd(63, rdm(17'(BASE + 5 * N + 63)), "R9 new entry after fetch");
    drain();

    // R7 simultaneous request: fetch first
    rdy_cyc = 0; done_cyc = 0;
    fork
      line_pulse(9);
      cpu_acc(0, 17'h00100, 0, pat(17'h00100));
    join
    drain();
    chk("R7 rdy after done", rdy_cyc > done_cyc, 1);
    chk("R7 done seen", done_cyc != 0, 1);

    // R8 access in progress completes first
    rdy_cyc = 0; done_cyc = 0;
    fork
      cpu_acc(0, 17'h00200, 0, pat(17'h00200));
      begin @(posedge clk); line_pulse(11); end
    join
    wait_done();
    chk("R8 rdy before done", (rdy_cyc != 0) && (rdy_cyc < done_cyc), 1);
    disp_rd(0, rdm(17'(BASE + 11 * N)), "R8 fetch after cpu entry 0");
    drain();

    chk("R3 no enable overlap", clash, 0);
    chk("R4 burst address step", step_err, 0);
    chk("R2 scoreboard empty", cq.size(), 0);
    finish_up();
  end
endmodule